// File: doc/BRIEF.md
# Selectable-Order Sinc Decimation Filter

This block turns a one-bit oversampled bitstream from a sigma-delta modulator into signed output words at a programmable rate. It is built as one cascade of four integrators and four combs. A single select input picks the response at run time. In fourth-order mode the whole cascade is used. In third-order mode the last integrator and the last comb are skipped. A rate field sets how many modulator samples make up each output period.

The block counts only the clocks where the modulator strobe is high. With one strobe every 16 master clocks, the default ratio of 64 samples per rate unit gives one word every 1024 × FS master clocks. Several events restart the filter: a reset, a pulse on the resync input, or any change of the rate field or the order select. A restart clears the whole cascade and hides the words that the filter produces while it is still settling. Each word that is finally released is marked by a one-clock ready pulse. The data bus then holds that word until the next one is released.

Top module: `sinc_decim_filter`

## Requirements
- R1: `order_sel` = 0 gives the fourth-order response (N = 4). `order_sel` = 1 gives the third-order response (N = 3). The order sets both the gain and the output scaling of R5.
- R2: One filter decision is made for every R = UNIT × FS accepted modulator samples, where FS is the unsigned value of `rate_div`. With a strobe on every clock, released words are R clocks apart. With a strobe on every other clock, they are 2R clocks apart.
- R3: A `rate_div` value of 0 behaves exactly like a value of 1. The decision period is then UNIT samples.
- R4: After a restart, the first N−1 decisions are suppressed. The first `data_rdy` pulse is visible in the clock that follows the edge which takes the N·R-th accepted sample after the restart edge, plus one register stage. With a strobe every d clocks, starting on the first edge after the restart, that pulse follows edge number (N·R−1)·d+2.
- R5: Each `mod_bit` counts as +1 when it is 1 and as −1 when it is 0. Take an input that repeats with period R and whose sum over one period is S. For that input, every released word equals floor(S·R^(N−1) / 2^SH) in two's complement, clamped to the signed `OUT_W`-bit range. SH is N·RB − (OUT_W−1), where RB = clog2(UNIT·(2^FS_W−1)+1).
- R6: Three events each restart the filter with the same timing as R4: a high level on `resync` at a clock edge, a change of `rate_div`, or a change of `order_sel`.
- R7: `data_rdy` is high for exactly one clock per released word. `data_out` keeps its value on every clock where `data_rdy` is low.
- R8: While `rst_n` is low, `data_out` reads 0 and `data_rdy` reads 0. The last reset edge acts as a restart edge for R4.
- R9: On clocks where `mod_stb` is low, `mod_bit` has no effect on the result. Those clocks also do not advance the decision count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_bit | input | 1 | Modulator bit; 1 means +1, 0 means −1 |
| mod_stb | input | 1 | High on clocks that carry a modulator sample |
| order_sel | input | 1 | 0 selects fourth order, 1 selects third order |
| rate_div | input | FS_W | Rate multiplier FS; 0 is treated as 1 |
| resync | input | 1 | Restarts the filter and its settling count |
| data_out | output | OUT_W | Last released word, signed |
| data_rdy | output | 1 | One-clock pulse marking a new word |

## Verification
A released word is registered once behind a decision flag, and that flag is itself registered on the edge that takes the R-th sample of a period. The first pulse after a restart therefore lands on edge (N·R−1)·d+2, and later pulses follow every R·d edges. The bench counts edges from the restart edge, samples on the falling edge, and compares the pulse position against that formula. It compares the word carried by each pulse against the closed-form value of R5. On every clock between pulses it confirms that the bus has not moved.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

   // highest filter order the cascade is built for; the low mode drops one stage
   parameter int MAX_ORDER = 4;

   typedef enum logic {
      ORD_HIGH = 1'b0,
      ORD_LOW  = 1'b1
   } order_e;

   // bits needed to hold the largest decimation ratio
   function automatic int ratio_bits(input int unit, input int fs_w);
      return $clog2(unit * ((1 << fs_w) - 1) + 1);
   endfunction

endpackage

// File: rtl/sdf_decim_ctrl.sv
module sdf_decim_ctrl
   import sdf_pkg::*;
#(
   parameter int FS_W  = 10,
   parameter int UNIT  = 64,
   parameter int CNT_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mod_stb,
   input  logic            order_sel,
   input  logic [FS_W-1:0] rate_div,
   input  logic            resync,
   output logic            restart,
   output logic            dump,
   output logic            keep
);

   localparam int SET_W = $clog2(MAX_ORDER + 1);

   logic [FS_W-1:0]  fs_q;
   logic             ord_q;
   logic [FS_W-1:0]  fs_eff;
   logic [CNT_W-1:0] ratio;
   logic [CNT_W-1:0] samp_cnt;
   logic [SET_W-1:0] settle;
   logic [SET_W-1:0] need_m1;

   always_comb begin
      fs_eff  = (rate_div == '0) ? FS_W'(1) : rate_div;
      ratio   = CNT_W'(UNIT) * CNT_W'(fs_eff);
      restart = resync | (rate_div != fs_q) | (order_sel != ord_q);
      need_m1 = (order_e'(order_sel) == ORD_LOW) ? SET_W'(MAX_ORDER - 2)
                                                 : SET_W'(MAX_ORDER - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q     <= rate_div;
         ord_q    <= order_sel;
         samp_cnt <= '0;
         settle   <= '0;
         dump     <= 1'b0;
         keep     <= 1'b0;
      end else begin
         fs_q  <= rate_div;
         ord_q <= order_sel;
         dump  <= 1'b0;
         keep  <= 1'b0;
         if (restart) begin
            samp_cnt <= '0;
            settle   <= '0;
         end else if (mod_stb) begin
            if (samp_cnt == ratio - CNT_W'(1)) begin
               samp_cnt <= '0;
               dump     <= 1'b1;
               keep     <= (settle >= need_m1);
               if (settle < need_m1) begin
                  settle <= settle + SET_W'(1);
               end
            end else begin
               samp_cnt <= samp_cnt + CNT_W'(1);
            end
         end
      end
   end

   // R2: the sample counter never passes the active ratio
   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (samp_cnt < ratio));

   // R9: a decision only follows a clock that carried a sample
   assert_dump_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dump |-> $past(mod_stb));

   // R4: release is only granted together with a decision
   assert_keep_with_dump_R4: assert property (@(posedge clk) disable iff (!rst_n)
      keep |-> dump);

   // R4: the settling count stays inside the blanking window
   assert_settle_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      settle <= SET_W'(MAX_ORDER - 1));

endmodule

// File: rtl/sdf_integrators.sv
module sdf_integrators #(
   parameter int ACC_W  = 65,
   parameter int STAGES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          stb,
   input  logic                          bit_in,
   output logic [STAGES-1:0][ACC_W-1:0]  taps
);

   logic [ACC_W-1:0] acc [STAGES];
   logic [ACC_W-1:0] step;

   // +1 for a one, all ones (-1) for a zero
   assign step = {{(ACC_W-1){~bit_in}}, 1'b1};

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [ACC_W-1:0] addend;
      if (s == 0) begin : g_head
         assign addend = step;
      end else begin : g_chain
         assign addend = acc[s-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            acc[s] <= '0;
         end else if (stb) begin
            acc[s] <= acc[s] + addend;
         end
      end

      assign taps[s] = acc[s];
   end

   // R6: a restart leaves every integrator at zero
   assert_integ_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> (taps == '0));

   // R9: integrators only move on strobed clocks
   assert_integ_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(stb) && !$past(clear)) |-> $stable(taps));

endmodule

// File: rtl/sdf_combs.sv
module sdf_combs
   import sdf_pkg::*;
#(
   parameter int ACC_W  = 65,
   parameter int STAGES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          dump,
   input  logic                          order_sel,
   input  logic [STAGES-1:0][ACC_W-1:0]  taps,
   output logic [ACC_W-1:0]              result
);

   logic [ACC_W-1:0] stage_in  [STAGES+1];
   logic [ACC_W-1:0] dly       [STAGES];
   logic             low_mode;

   assign low_mode    = (order_e'(order_sel) == ORD_LOW);
   // the low-order mode taps one integrator earlier and stops one comb earlier
   assign stage_in[0] = low_mode ? taps[STAGES-2] : taps[STAGES-1];

   for (genvar s = 0; s < STAGES; s++) begin : g_comb
      assign stage_in[s+1] = stage_in[s] - dly[s];

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            dly[s] <= '0;
         end else if (dump) begin
            dly[s] <= stage_in[s];
         end
      end
   end

   assign result = low_mode ? stage_in[STAGES-1] : stage_in[STAGES];

   // R6: a restart empties the comb delay line
   assert_comb_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> (dly[0] == '0 && dly[STAGES-1] == '0));

   // R2: comb state only advances on a decision
   assert_comb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(dump) && !$past(clear)) |-> $stable(dly[0]));

endmodule

// File: rtl/sdf_out_scale.sv
module sdf_out_scale
   import sdf_pkg::*;
#(
   parameter int ACC_W = 65,
   parameter int OUT_W = 24,
   parameter int SH_HI = 41,
   parameter int SH_LO = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             order_sel,
   input  logic [ACC_W-1:0] result,
   output logic [OUT_W-1:0] data_out,
   output logic             data_rdy
);

   localparam logic signed [ACC_W-1:0] POS_LIM =
      {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] NEG_LIM =
      {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [ACC_W-1:0] scaled;
   logic        [OUT_W-1:0] clamped;

   generate
      if (SH_HI == SH_LO) begin : g_one_shift
         always_comb scaled = $signed(result) >>> SH_HI;
      end else begin : g_two_shift
         always_comb begin
            if (order_e'(order_sel) == ORD_LOW) begin
               scaled = $signed(result) >>> SH_LO;
            end else begin
               scaled = $signed(result) >>> SH_HI;
            end
         end
      end
   endgenerate

   always_comb begin
      if (scaled > POS_LIM) begin
         clamped = POS_LIM[OUT_W-1:0];
      end else if (scaled < NEG_LIM) begin
         clamped = NEG_LIM[OUT_W-1:0];
      end else begin
         clamped = scaled[OUT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_out <= '0;
         data_rdy <= 1'b0;
      end else begin
         data_rdy <= load;
         if (load) begin
            data_out <= clamped;
         end
      end
   end

endmodule

// File: rtl/sinc_decim_filter.sv
module sinc_decim_filter
   import sdf_pkg::*;
#(
   parameter int OUT_W = 24,
   parameter int FS_W  = 10,
   parameter int UNIT  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_bit,
   input  logic             mod_stb,
   input  logic             order_sel,
   input  logic [FS_W-1:0]  rate_div,
   input  logic             resync,
   output logic [OUT_W-1:0] data_out,
   output logic             data_rdy
);

   localparam int RBITS = ratio_bits(UNIT, FS_W);
   localparam int ACC_W = MAX_ORDER * RBITS + 1;
   localparam int SH_HI = MAX_ORDER * RBITS - (OUT_W - 1);
   localparam int SH_LO = (MAX_ORDER - 1) * RBITS - (OUT_W - 1);

   // elaboration-time parameter checks
   if (UNIT < 2) begin : g_bad_unit
      $error("UNIT must be at least 2");
   end
   if (FS_W < 1 || FS_W > 16) begin : g_bad_fs
      $error("FS_W must lie in 1..16");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("OUT_W must be at least 2");
   end
   if (SH_LO < 0 || ACC_W < OUT_W) begin : g_bad_scale
      $error("OUT_W is too wide for the configured ratio range");
   end
   if (MAX_ORDER < 2) begin : g_bad_order
      $error("MAX_ORDER must be at least 2");
   end

   logic                             restart;
   logic                             dump;
   logic                             keep;
   logic                             load;
   logic [MAX_ORDER-1:0][ACC_W-1:0]  taps;
   logic [ACC_W-1:0]                 result;

   sdf_decim_ctrl #(
      .FS_W  (FS_W),
      .UNIT  (UNIT),
      .CNT_W (RBITS)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mod_stb   (mod_stb),
      .order_sel (order_sel),
      .rate_div  (rate_div),
      .resync    (resync),
      .restart   (restart),
      .dump      (dump),
      .keep      (keep)
   );

   sdf_integrators #(
      .ACC_W  (ACC_W),
      .STAGES (MAX_ORDER)
   ) integ_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (restart),
      .stb    (mod_stb),
      .bit_in (mod_bit),
      .taps   (taps)
   );

   sdf_combs #(
      .ACC_W  (ACC_W),
      .STAGES (MAX_ORDER)
   ) comb_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (restart),
      .dump      (dump & ~restart),
      .order_sel (order_sel),
      .taps      (taps),
      .result    (result)
   );

   assign load = dump & keep & ~restart;

   sdf_out_scale #(
      .ACC_W (ACC_W),
      .OUT_W (OUT_W),
      .SH_HI (SH_HI),
      .SH_LO (SH_LO)
   ) scale_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .order_sel (order_sel),
      .result    (result),
      .data_out  (data_out),
      .data_rdy  (data_rdy)
   );

   // R7: ready is a single-clock pulse
   assert_rdy_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy |=> !data_rdy);

   // R7: the word holds while ready is low
   assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !data_rdy |-> (data_out == $past(data_out)));

   // R4: a released word always stems from a settled decision
   assert_rdy_after_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy |-> $past(keep));

   // R6: nothing is released on the clock right after a restart
   assert_no_rdy_after_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(restart) |-> !data_rdy);

endmodule

// File: tb/sinc_decim_filter_tb_top.sv
module sinc_decim_filter_tb_top;

   localparam int OUT_W = 12;
   localparam int FS_W  = 3;
   localparam int UNIT  = 4;
   localparam int RB    = $clog2(UNIT * ((1 << FS_W) - 1) + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mod_bit = 1'b0;
   logic             mod_stb = 1'b0;
   logic             order_sel = 1'b0;
   logic [FS_W-1:0]  rate_div = FS_W'(1);
   logic             resync = 1'b0;
   logic [OUT_W-1:0] data_out;
   logic             data_rdy;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   sinc_decim_filter #(
      .OUT_W (OUT_W),
      .FS_W  (FS_W),
      .UNIT  (UNIT)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mod_bit   (mod_bit),
      .mod_stb   (mod_stb),
      .order_sel (order_sel),
      .rate_div  (rate_div),
      .resync    (resync),
      .data_out  (data_out),
      .data_rdy  (data_rdy)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint expect_word(input int n_ord, input int r, input int k);
      longint v = longint'(2 * k - r);
      int sh = n_ord * RB - (OUT_W - 1);
      longint lim = longint'(1) <<< (OUT_W - 1);
      for (int i = 1; i < n_ord; i++) v = v * r;
      v = v >>> sh;
      if (v > lim - 1) v = lim - 1;
      if (v < -lim) v = -lim;
      return v;
   endfunction

   // kind: 0 = reset, 1 = resync pulse, 2 = configuration change only
   task automatic run_case(input int kind, input logic ord, input int fs,
                           input int k, input int div, input string tag_start);
      int n_ord = ord ? 3 : 4;
      int r = UNIT * ((fs == 0) ? 1 : fs);
      longint ev = expect_word(n_ord, r, k);
      int due = (n_ord * r - 1) * div + 2;
      int limit = due + r * div + 6;
      int seen = 0;
      int first_at = -1;
      int second_at = -1;
      int samp = 0;
      longint v1 = 0;
      longint v2 = 0;
      bit hold_ok = 1'b1;
      bit prev_rdy = 1'b0;
      logic [OUT_W-1:0] held;

      @(negedge clk);
      mod_stb   = 1'b0;
      order_sel = ord;
      rate_div  = FS_W'(fs);
      if (kind == 0) begin
         rst_n = 1'b0;
         @(negedge clk);
         @(negedge clk);
         check(data_out == '0, "R8 reset word", longint'(data_out), 0);
         check(data_rdy == 1'b0, "R8 reset ready", longint'(data_rdy), 0);
         rst_n = 1'b1;
      end else begin
         if (kind == 1) resync = 1'b1;
         @(negedge clk);
         resync = 1'b0;
      end

      held = data_out;
      for (int cyc = 1; cyc <= limit && seen < 2; cyc++) begin
         if ((cyc - 1) % div == 0) begin
            mod_stb = 1'b1;
            mod_bit = ((samp % r) < k);
            samp++;
         end else begin
            mod_stb = 1'b0;
            mod_bit = ~mod_bit;   // must be ignored (R9)
         end
         @(negedge clk);
         if (data_rdy) begin
            if (prev_rdy) hold_ok = 1'b0;
            seen++;
            if (seen == 1) begin
               first_at = cyc;
               v1 = longint'($signed(data_out));
            end else begin
               second_at = cyc;
               v2 = longint'($signed(data_out));
            end
            held = data_out;
         end else if (data_out !== held) begin
            hold_ok = 1'b0;
         end
         prev_rdy = data_rdy;
      end
      mod_stb = 1'b0;

      check(first_at == due, tag_start, first_at, due);
      if (fs == 0)
         check(second_at - first_at == r * div, "R3 period with zero field", second_at - first_at, r * div);
      else if (div > 1)
         check(second_at - first_at == r * div, "R9 period with gapped strobe", second_at - first_at, r * div);
      else
         check(second_at - first_at == r * div, "R2 decision period", second_at - first_at, r * div);
      check(v1 == ev, ord ? "R5 R1 first word third order" : "R5 R1 first word fourth order", v1, ev);
      check(v2 == ev, div > 1 ? "R9 R5 second word gapped" : "R5 second word", v2, ev);
      check(hold_ok, "R7 single pulse and held word", longint'(hold_ok), 1);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : stimulus
      repeat (3) @(negedge clk);
      // reset as restart (R8, R4)
      run_case(0, 1'b0, 1, 4, 1, "R8 R4 first word after reset");

      // near-exhaustive density sweep over small rates, both orders (R1, R2, R4, R5)
      for (int o = 0; o < 2; o++) begin
         for (int fs = 1; fs <= 2; fs++) begin
            for (int k = 0; k <= UNIT * fs; k++) begin
               run_case(1, logic'(o), fs, k, 1, "R6 R4 first word after resync");
            end
         end
      end

      // largest ratio, full-scale and mid densities
      run_case(1, 1'b0, 7, 0, 1, "R4 first word max rate");
      run_case(1, 1'b0, 7, 28, 1, "R4 first word max rate");
      run_case(1, 1'b0, 7, 11, 1, "R4 first word max rate");
      run_case(1, 1'b1, 7, 0, 1, "R4 first word max rate");
      run_case(1, 1'b1, 7, 28, 1, "R4 first word max rate");
      run_case(1, 1'b1, 7, 17, 1, "R4 first word max rate");

      // restart by rate change alone, with zero rate field (R6, R3)
      run_case(2, 1'b1, 0, 1, 1, "R6 first word after rate change");
      // restart by order change alone (R6, R1)
      run_case(2, 1'b0, 0, 3, 1, "R6 first word after order change");

      // gapped strobe with toggling bit on idle clocks (R9)
      run_case(1, 1'b0, 3, 5, 2, "R9 R4 first word gapped strobe");
      run_case(1, 1'b1, 3, 9, 2, "R9 R4 first word gapped strobe");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule